// File: doc/BRIEF.md
# Software-Pipelined Loop Branch Resolver

This block resolves the branches that close software-pipelined loops and plain counted loops. It keeps a loop counter, an epilog counter, a base offset for a rotating register region and a stage predicate. Each cycle it can accept one branch request. The request names a loop flavour and carries a qualifying predicate bit. The block answers in the same cycle with a taken flag. At the next clock edge it updates its counters, the rotation base and the predicate.

A pipelined loop runs in two phases. In the kernel phase the loop condition holds, and each pass renames registers by rotating the base. In the epilog phase the pipeline drains: the epilog counter counts down while rotation goes on, until the last stage has retired. Counted flavours take their kernel condition from the loop counter. While flavours take it from the predicate bit. The top flavours signal "keep looping" by taking the branch. The exit flavours signal it by falling through, so the taken flag is inverted between the two. Software can load either counter directly, and such a load wins over any branch update in the same cycle.

Top module: `loop_branch_unit`

## Requirements
- R1: While reset is asserted, and directly after it, the loop counter, epilog counter, rotation base and stage predicate all read zero.
- R2: Opcode encoding on `br_op` is 0 = simple counted, 1 = counted-top, 2 = counted-exit, 3 = while-top, 4 = while-exit. When `br_valid` is low, or the code is 5, 6 or 7, `br_taken` is 0 and no state changes apart from software loads.
- R3: Simple counted with a nonzero loop counter: the branch is taken and the loop counter drops by one. The epilog counter, rotation base and predicate stay unchanged, and `br_qp` has no effect.
- R4: Simple counted with a zero loop counter: the branch falls through and no state changes.
- R5: Kernel condition: for counted flavours (1, 2) it is "loop counter nonzero", and in the kernel phase they decrement the loop counter. For while flavours (3, 4) it is `br_qp`, and they never change the loop counter.
- R6: Kernel phase: the epilog counter is unchanged, the predicate becomes 1 and the base rotates. Top flavours are taken and exit flavours fall through.
- R7: Epilog phase with the epilog counter above one: the epilog counter drops by one, the predicate becomes 0 and the base rotates. Top flavours are taken and exit flavours fall through.
- R8: Epilog phase with the epilog counter equal to one: the epilog counter becomes 0, the predicate becomes 0 and the base rotates. Top flavours fall through and exit flavours are taken.
- R9: Epilog phase with the epilog counter at zero: the epilog counter stays 0, the base does not move and the predicate becomes 0. Top flavours fall through and exit flavours are taken.
- R10: A rotation decrements the base by one modulo `ROT_SIZE`, so 0 wraps to `ROT_SIZE-1`. The base always stays below `ROT_SIZE`.
- R11: A software load of either counter sets it to the loaded value at the next edge, overriding any branch update of that counter. The other effects of the branch still take place.
- R12: `br_taken` depends combinationally on the current request and state. The state updates become visible after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A branch request is present this cycle |
| br_op | input | 3 | Loop flavour code |
| br_qp | input | 1 | Qualifying predicate, used as the while-loop kernel condition |
| lc_wr_en | input | 1 | Software load of the loop counter |
| lc_wr_data | input | LC_W | Value to load into the loop counter |
| ec_wr_en | input | 1 | Software load of the epilog counter |
| ec_wr_data | input | EC_W | Value to load into the epilog counter |
| br_taken | output | 1 | Branch decision for the current request |
| lc_q | output | LC_W | Loop counter |
| ec_q | output | EC_W | Epilog counter |
| rot_base | output | ROT_W | Rotating region base offset |
| stage_pred | output | 1 | Stage predicate |

## Verification
Every piece of state is a port, so a corrupted counter, base or predicate shows up at the next clock edge, when the bench compares all outputs against its model. A wrong phase choice shows even sooner, through `br_taken` in the same cycle. The fragile spots are the move from an epilog counter of one to zero, repeated requests with the counter already at zero, wrap-around of the rotation base, and a software load colliding with a branch. The directed sequences steer into each of these, and a long random run mixes them.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

  typedef enum logic [2:0] {
    OP_CLOOP = 3'd0,
    OP_CTOP  = 3'd1,
    OP_CEXIT = 3'd2,
    OP_WTOP  = 3'd3,
    OP_WEXIT = 3'd4
  } lbu_op_e;

  // One request's decided effect on the state
  typedef struct packed {
    logic taken;
    logic lc_dec;
    logic ec_dec;
    logic rotate;
    logic pred_wr;
    logic pred_val;
  } lbu_act_t;

endpackage

// File: rtl/lbu_decide.sv
module lbu_decide
  import lbu_pkg::*;
#(
  parameter int LC_W = 8,
  parameter int EC_W = 6
) (
  input  logic            br_valid,
  input  logic [2:0]      br_op,
  input  logic            br_qp,
  input  logic [LC_W-1:0] lc,
  input  logic [EC_W-1:0] ec,
  output lbu_act_t        act
);

  logic lc_nz, ec_nz, ec_gt1;
  logic is_pipe, is_cnt, is_top, kern, stay;

  assign lc_nz  = |lc;
  assign ec_nz  = |ec;
  assign ec_gt1 = (ec > EC_W'(1));

  always_comb begin
    is_pipe = 1'b0;
    is_cnt  = 1'b0;
    is_top  = 1'b0;
    case (lbu_op_e'(br_op))
      OP_CTOP:  begin is_pipe = 1'b1; is_cnt = 1'b1; is_top = 1'b1; end
      OP_CEXIT: begin is_pipe = 1'b1; is_cnt = 1'b1; end
      OP_WTOP:  begin is_pipe = 1'b1; is_top = 1'b1; end
      OP_WEXIT: begin is_pipe = 1'b1; end
      default:  ;
    endcase
  end

  assign kern = is_cnt ? lc_nz : br_qp;

  always_comb begin
    act  = '0;
    stay = 1'b0;
    if (br_valid) begin
      if (lbu_op_e'(br_op) == OP_CLOOP) begin
        act.taken  = lc_nz;
        act.lc_dec = lc_nz;
      end else if (is_pipe) begin
        act.pred_wr = 1'b1;
        if (kern) begin
          act.lc_dec   = is_cnt;
          act.rotate   = 1'b1;
          act.pred_val = 1'b1;
          stay         = 1'b1;
        end else if (ec_gt1) begin
          act.ec_dec = 1'b1;
          act.rotate = 1'b1;
          stay       = 1'b1;
        end else if (ec_nz) begin
          act.ec_dec = 1'b1;
          act.rotate = 1'b1;
        end
        act.taken = is_top ? stay : !stay;
      end
    end
  end

endmodule

// File: rtl/lbu_cnt.sv
module lbu_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         dec,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;
  logic         q_en;

  assign q_en = wr_en | dec;

  always_comb begin
    if (wr_en) q_nxt = wr_data;
    else       q_nxt = q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  // R9: a countdown never starts from zero
  assert_dec_from_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (q != '0));

  // R11: a load lands exactly
  assert_load_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (q == $past(wr_data)));

endmodule

// File: rtl/lbu_rot.sv
module lbu_rot #(
  parameter int SIZE = 8,
  localparam int W = (SIZE > 1) ? $clog2(SIZE) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rotate,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] LAST = W'(SIZE - 1);

  logic [W-1:0] q_nxt;

  generate
    if ((SIZE & (SIZE - 1)) == 0) begin : g_pow2
      assign q_nxt = q - W'(1);
    end else begin : g_gen
      assign q_nxt = (q == '0) ? LAST : (q - W'(1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (rotate) q <= q_nxt;
  end

  assert_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    q <= LAST);

  assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && q == '0) |=> (q == LAST));

endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
  import lbu_pkg::*;
#(
  parameter int LC_W     = 8,
  parameter int EC_W     = 6,
  parameter int ROT_SIZE = 8,
  localparam int ROT_W   = (ROT_SIZE > 1) ? $clog2(ROT_SIZE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic [2:0]       br_op,
  input  logic             br_qp,
  input  logic             lc_wr_en,
  input  logic [LC_W-1:0]  lc_wr_data,
  input  logic             ec_wr_en,
  input  logic [EC_W-1:0]  ec_wr_data,
  output logic             br_taken,
  output logic [LC_W-1:0]  lc_q,
  output logic [EC_W-1:0]  ec_q,
  output logic [ROT_W-1:0] rot_base,
  output logic             stage_pred
);

  lbu_act_t act;
  logic     pred_nxt;

  lbu_decide #(.LC_W(LC_W), .EC_W(EC_W)) u_decide (
    .br_valid (br_valid),
    .br_op    (br_op),
    .br_qp    (br_qp),
    .lc       (lc_q),
    .ec       (ec_q),
    .act      (act)
  );

  lbu_cnt #(.W(LC_W)) u_lc (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (lc_wr_en),
    .wr_data (lc_wr_data),
    .dec     (act.lc_dec),
    .q       (lc_q)
  );

  lbu_cnt #(.W(EC_W)) u_ec (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ec_wr_en),
    .wr_data (ec_wr_data),
    .dec     (act.ec_dec),
    .q       (ec_q)
  );

  lbu_rot #(.SIZE(ROT_SIZE)) u_rot (
    .clk    (clk),
    .rst_n  (rst_n),
    .rotate (act.rotate),
    .q      (rot_base)
  );

  assign br_taken = act.taken;
  assign pred_nxt = act.pred_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           stage_pred <= 1'b0;
    else if (act.pred_wr) stage_pred <= pred_nxt;
  end

  // Checks formed at the ports
  logic op_pipe, op_cnt, kern_chk;
  assign op_pipe  = (br_op >= 3'd1) && (br_op <= 3'd4);
  assign op_cnt   = (br_op == 3'd1) || (br_op == 3'd2);
  assign kern_chk = op_cnt ? (lc_q != '0) : br_qp;

  assert_idle_not_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid || br_op > 3'd4) |-> !br_taken);

  assert_cloop_zero_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_op == 3'd0 && lc_q == '0 && !lc_wr_en) |=> $stable(lc_q));

  assert_kernel_pred_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && op_pipe && kern_chk) |=> stage_pred);

  assert_ec_zero_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && op_pipe && !kern_chk && ec_q == '0 && !ec_wr_en)
      |=> (ec_q == '0 && $stable(rot_base) && !stage_pred));

endmodule

// File: tb/sim_loop_branch_unit.sv
`timescale 1ns/1ps
module sim_loop_branch_unit;

  localparam int LC_W = 8, EC_W = 6, RSZ = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic br_valid, br_qp, lc_wr_en, ec_wr_en;
  logic [2:0] br_op;
  logic [LC_W-1:0] lc_wr_data;
  logic [EC_W-1:0] ec_wr_data;
  logic br_taken, stage_pred;
  logic [LC_W-1:0] lc_q;
  logic [EC_W-1:0] ec_q;
  logic [2:0] rot_base;

  always #5 clk = ~clk;

  loop_branch_unit #(.LC_W(LC_W), .EC_W(EC_W), .ROT_SIZE(RSZ)) u0 (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_op(br_op), .br_qp(br_qp),
    .lc_wr_en(lc_wr_en), .lc_wr_data(lc_wr_data), .ec_wr_en(ec_wr_en),
    .ec_wr_data(ec_wr_data), .br_taken(br_taken), .lc_q(lc_q), .ec_q(ec_q),
    .rot_base(rot_base), .stage_pred(stage_pred));

  int total = 0, bad = 0;
  int m_lc = 0, m_ec = 0, m_rot = 0, m_pred = 0;
  bit finished = 0;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string klass(bit v, int op, bit qp);
    bit kern;
    if (!v || op > 4) return "R2";
    if (op == 0) return (m_lc != 0) ? "R3" : "R4";
    kern = (op <= 2) ? (m_lc != 0) : qp;
    if (kern) return "R6";
    if (m_ec > 1) return "R7";
    if (m_ec == 1) return "R8";
    return "R9";
  endfunction

  task automatic check_state(string tag, bit lw, bit ew, bit pipe);
    chk(lw ? "R11" : (pipe ? "R5" : tag), "lc", int'(lc_q), m_lc);
    chk(ew ? "R11" : tag, "ec", int'(ec_q), m_ec);
    chk("R10", "rot", int'(rot_base), m_rot);
    chk(tag, "pred", int'(stage_pred), m_pred);
  endtask

  // One request cycle: drive after the falling edge, check taken, step model at the rising edge
  task automatic cyc(bit v, int op, bit qp, bit lw, int ld, bit ew, int ed);
    bit kern, stay, exp_t, pipe;
    string tag;
    br_valid = v; br_op = 3'(op); br_qp = qp;
    lc_wr_en = lw; lc_wr_data = LC_W'(ld);
    ec_wr_en = ew; ec_wr_data = EC_W'(ed);
    tag  = klass(v, op, qp);
    pipe = v && op >= 1 && op <= 4;
    exp_t = 0;
    #1;
    if (v && op == 0) exp_t = (m_lc != 0);
    else if (pipe) begin
      kern = (op <= 2) ? (m_lc != 0) : qp;
      stay = kern || (m_ec > 1);
      exp_t = (op == 1 || op == 3) ? stay : !stay;
    end
    // R12: the decision appears before the clock edge
    chk(tag, "taken", int'(br_taken), int'(exp_t));
    @(posedge clk);
    if (v && op == 0) begin
      if (m_lc != 0) m_lc--;
    end else if (pipe) begin
      m_pred = kern;
      if (kern) begin
        if (op <= 2) m_lc--;
        m_rot = (m_rot + RSZ - 1) % RSZ;
      end else if (m_ec >= 1) begin
        m_ec--;
        m_rot = (m_rot + RSZ - 1) % RSZ;
      end
    end
    if (lw) m_lc = ld;
    if (ew) m_ec = ed;
    @(negedge clk);
    check_state(tag, lw, ew, pipe);
  endtask

  task automatic load(int lc, int ec);
    cyc(0, 0, 0, 1, lc, 1, ec);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
    end
  end

  initial begin
    rst_n = 0; br_valid = 0; br_op = 0; br_qp = 0;
    lc_wr_en = 0; ec_wr_en = 0; lc_wr_data = 0; ec_wr_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "lc", int'(lc_q), 0);
    chk("R1", "ec", int'(ec_q), 0);
    chk("R1", "rot", int'(rot_base), 0);
    chk("R1", "pred", int'(stage_pred), 0);
    rst_n = 1;
    @(negedge clk);
    check_state("R1", 0, 0, 0);

    // Simple counted loop, predicate toggled to show it is ignored
    load(3, 2);
    for (int i = 0; i < 5; i++) cyc(1, 0, i[0], 0, 0, 0, 0);
    // Idle and unassigned codes
    load(4, 3);
    for (int op = 5; op < 8; op++) cyc(1, op, 1, 0, 0, 0, 0);
    cyc(0, 1, 1, 0, 0, 0, 0);
    // Counted-top through kernel, epilog, exit and further zero-EC requests
    load(2, 3);
    for (int i = 0; i < 8; i++) cyc(1, 1, 0, 0, 0, 0, 0);
    // Counted-exit
    load(1, 2);
    for (int i = 0; i < 5; i++) cyc(1, 2, 1, 0, 0, 0, 0);
    // While-top and while-exit
    load(5, 2);
    for (int i = 0; i < 6; i++) cyc(1, 3, (i < 2), 0, 0, 0, 0);
    load(5, 3);
    for (int i = 0; i < 6; i++) cyc(1, 4, (i < 2), 0, 0, 0, 0);
    // Long kernel run to wrap the rotation base
    load(0, 1);
    for (int i = 0; i < 2 * RSZ + 1; i++) cyc(1, 3, 1, 0, 0, 0, 0);
    // Loads colliding with branch updates
    load(3, 3);
    cyc(1, 1, 0, 1, 9, 0, 0);
    cyc(1, 1, 0, 0, 0, 1, 7);
    cyc(1, 2, 0, 1, 0, 1, 1);
    cyc(1, 0, 0, 1, 6, 0, 0);
    cyc(1, 4, 0, 0, 0, 1, 0);

    for (int i = 0; i < 3000; i++) begin
      int r = $urandom % 100;
      int op = (r < 90) ? ($urandom % 5) : (5 + $urandom % 3);
      bit v = ($urandom % 10) != 0;
      bit lw = ($urandom % 10) == 0;
      bit ew = ($urandom % 10) == 0;
      cyc(v, op, ($urandom % 3) != 0, lw, $urandom % 5, ew, $urandom % 5);
    end

    finished = 1;
    summary();
  end

endmodule